// File: doc/BRIEF.md
# Baud Tick Generator

This block produces the timing ticks of a serial port. A programmable down-counter reloads from a divisor value `n` and gives a one-cycle `sub_tick` every `n+1` clocks. A prescale stage then divides that stream by 64, 16 or 4 into a one-cycle `bit_tick` per serial bit. The prescale depends on three mode inputs: synchronous select, wide (16-bit) counter select and fast select. The divisor is held in two byte registers, low and high, and each has its own write strobe. A write to either one restarts the counter and the prescale stage at once, so the new rate starts straight away.

The block also recovers the receive line. Within each bit period, a small state machine takes three samples of `rx_in` on consecutive sub-ticks centred on the middle of the bit. It registers the two-of-three majority on `rx_bit`. The voter has three states. `VOTE_IDLE` goes to `VOTE_HAVE_A` on the sub-tick whose prescale index is `P/2-1`, and stores the first sample. `VOTE_HAVE_A` goes to `VOTE_HAVE_B` on the next sub-tick and stores the second sample. `VOTE_HAVE_B` goes back to `VOTE_IDLE` on the next sub-tick and registers the vote. A divisor write sends any state to `VOTE_IDLE`.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted, `sub_tick` and `bit_tick` are 0 and `rx_bit` is 1. Both divisor bytes reset to 0.
- R2: The effective divisor `n` is `{hi,lo}` when `sel_wide`=1. When `sel_wide`=0 it is the low byte only, and the high byte has no effect. `sub_tick` then repeats every `n+1` cycles.
- R3: Prescale P is 64 for async/narrow/slow, 16 for async/narrow/fast and 16 for async/wide/slow. It is 4 for async/wide/fast. `bit_tick` repeats every `P*(n+1)` cycles and is only high in a cycle where `sub_tick` is high.
- R4: With `sel_sync`=1, P is 4 for either counter width, and `sel_fast` has no effect on the period.
- R5: A write strobe on either divisor byte restarts the count. `sub_tick` is high in the first cycle after the write edge. The first `bit_tick` comes `(P-1)*(n+1)` cycles after that cycle.
- R6: With `n`=0, `sub_tick` is high every cycle and `bit_tick` still repeats every P cycles.
- R7: With a 16 MHz clock, async, narrow, slow and `n`=25, the bit period is 1664 cycles. That is about 9615 bits/s, 0.16% above 9600.
- R8: `rx_in` is sampled on the sub-ticks with prescale index P/2-1, P/2 and P/2+1, counting from the bit's first sub-tick as 0. The majority appears on `rx_bit` in the cycle after the third sample. At all other times `rx_bit` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_lo_data | input | 8 | Data for the divisor low byte |
| div_lo_we | input | 1 | Write strobe for the low byte (restarts count) |
| div_hi_data | input | 8 | Data for the divisor high byte |
| div_hi_we | input | 1 | Write strobe for the high byte (restarts count) |
| sel_sync | input | 1 | 1 = synchronous mode (prescale 4) |
| sel_wide | input | 1 | 1 = 16-bit divisor, 0 = low byte only |
| sel_fast | input | 1 | High-speed prescale select (async only) |
| rx_in | input | 1 | Receive line |
| sub_tick | output | 1 | One-cycle tick every n+1 clocks |
| bit_tick | output | 1 | One-cycle tick every P*(n+1) clocks |
| rx_bit | output | 1 | Registered majority of three samples |

## Verification
After a write, `sub_tick` is due in the first cycle after the write edge. `bit_tick` is due `(P-1)*(n+1)` cycles later. The voted bit is due one cycle after the sub-tick that takes the third sample. The bench starts each timing scenario with a divisor write and numbers the following cycles from that edge. It samples every output at the falling edge of each numbered cycle, so each check lands on the exact cycle where the result is due. Periods are measured between consecutive ticks, so mode changes never shift the reference point.

// File: rtl/brg_pkg.sv
package brg_pkg;

    localparam int IDX_W   = 6;
    localparam int SCALE_W = IDX_W + 1;

    typedef enum logic [1:0] {
        VOTE_IDLE   = 2'd0,
        VOTE_HAVE_A = 2'd1,
        VOTE_HAVE_B = 2'd2
    } vote_state_e;

    // Prescale chosen from the mode table.
    function automatic logic [SCALE_W-1:0] scale_for(input logic sync_m,
                                                     input logic wide_m,
                                                     input logic fast_m);
        logic [SCALE_W-1:0] s;
        if (sync_m) begin
            s = SCALE_W'(4);
        end else begin
            unique case ({wide_m, fast_m})
                2'b00:   s = SCALE_W'(64);
                2'b11:   s = SCALE_W'(4);
                default: s = SCALE_W'(16);
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/brg_reload_counter.sv
module brg_reload_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] reload,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q == '0) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = rst_n && (cnt_q == '0);

    // R5: a divisor write yields a tick in the very next cycle
    a_r5_restart_tick: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> tick);

    // R2: after a tick the counter holds the divisor value
    a_r2_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart) |=> (cnt_q == $past(reload)));

endmodule

// File: rtl/brg_prescale.sv
module brg_prescale
    import brg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               sub_tick,
    input  logic [SCALE_W-1:0] div_by,
    output logic [IDX_W-1:0]   idx,
    output logic               bit_tick
);

    logic [IDX_W-1:0]   idx_q;
    logic [SCALE_W-1:0] last_idx;
    logic               at_last;

    assign last_idx = div_by - SCALE_W'(1);
    assign at_last  = SCALE_W'(idx_q) >= last_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (restart) begin
            idx_q <= '0;
        end else if (sub_tick) begin
            idx_q <= at_last ? '0 : idx_q + 1'b1;
        end
    end

    assign idx      = idx_q;
    assign bit_tick = sub_tick && at_last;

    // R3: a bit tick only occurs together with a sub tick
    a_r3_bit_on_sub: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sub_tick);

    // R3: the bit index starts over after each bit tick
    a_r3_index_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !restart) |=> (idx_q == '0));

endmodule

// File: rtl/brg_rx_vote.sv
module brg_rx_vote
    import brg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               sub_tick,
    input  logic [IDX_W-1:0]   idx,
    input  logic [SCALE_W-1:0] div_by,
    input  logic               rx_in,
    output logic               rx_bit
);

    vote_state_e        st_q, st_d;
    logic [SCALE_W-1:0] first_idx;
    logic               samp_a_q, samp_b_q, rx_bit_q;
    logic               vote;

    assign first_idx = (div_by >> 1) - SCALE_W'(1);
    assign vote      = (samp_a_q & samp_b_q) | (samp_a_q & rx_in) | (samp_b_q & rx_in);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= VOTE_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d = VOTE_IDLE;
        end else if (sub_tick) begin
            unique case (st_q)
                VOTE_IDLE:   if (SCALE_W'(idx) == first_idx) st_d = VOTE_HAVE_A;
                VOTE_HAVE_A: st_d = VOTE_HAVE_B;
                VOTE_HAVE_B: st_d = VOTE_IDLE;
                default:     st_d = VOTE_IDLE;
            endcase
        end
    end

    // Sample and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_a_q <= 1'b1;
            samp_b_q <= 1'b1;
            rx_bit_q <= 1'b1;
        end else if (!restart && sub_tick) begin
            unique case (st_q)
                VOTE_IDLE:   if (st_d == VOTE_HAVE_A) samp_a_q <= rx_in;
                VOTE_HAVE_A: samp_b_q <= rx_in;
                VOTE_HAVE_B: rx_bit_q <= vote;
                default:     ;
            endcase
        end
    end

    assign rx_bit = rx_bit_q;

    // R8: the voted bit changes only after the third sample
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q == VOTE_HAVE_B && sub_tick && !restart) |=> $stable(rx_bit));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import brg_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] div_lo_data,
    input  logic              div_lo_we,
    input  logic [BYTE_W-1:0] div_hi_data,
    input  logic              div_hi_we,
    input  logic              sel_sync,
    input  logic              sel_wide,
    input  logic              sel_fast,
    input  logic              rx_in,
    output logic              sub_tick,
    output logic              bit_tick,
    output logic              rx_bit
);

    localparam int CNT_W = 2 * BYTE_W;

    logic [BYTE_W-1:0]  lo_q, hi_q;
    logic [CNT_W-1:0]   reload;
    logic               restart;
    logic [SCALE_W-1:0] div_by;
    logic [IDX_W-1:0]   idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (div_lo_we) lo_q <= div_lo_data;
            if (div_hi_we) hi_q <= div_hi_data;
        end
    end

    assign restart = div_lo_we | div_hi_we;
    assign reload  = sel_wide ? {hi_q, lo_q} : {{BYTE_W{1'b0}}, lo_q};
    assign div_by  = scale_for(sel_sync, sel_wide, sel_fast);

    brg_reload_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .reload  (reload),
        .tick    (sub_tick)
    );

    brg_prescale u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .sub_tick (sub_tick),
        .div_by   (div_by),
        .idx      (idx),
        .bit_tick (bit_tick)
    );

    brg_rx_vote u_vote (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .sub_tick (sub_tick),
        .idx      (idx),
        .div_by   (div_by),
        .rx_in    (rx_in),
        .rx_bit   (rx_bit)
    );

    // R1: no ticks are produced while reset is held
    a_r1_quiet_reset: assert property (@(posedge clk)
        !rst_n |-> (!sub_tick && !bit_tick));

endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_lo_data = '0;
    logic       div_lo_we = 1'b0;
    logic [7:0] div_hi_data = '0;
    logic       div_hi_we = 1'b0;
    logic       sel_sync = 1'b0;
    logic       sel_wide = 1'b0;
    logic       sel_fast = 1'b0;
    logic       rx_in = 1'b1;
    logic       sub_tick, bit_tick, rx_bit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    baud_tick_gen uut (
        .clk(clk), .rst_n(rst_n),
        .div_lo_data(div_lo_data), .div_lo_we(div_lo_we),
        .div_hi_data(div_hi_data), .div_hi_we(div_hi_we),
        .sel_sync(sel_sync), .sel_wide(sel_wide), .sel_fast(sel_fast),
        .rx_in(rx_in), .sub_tick(sub_tick), .bit_tick(bit_tick), .rx_bit(rx_bit)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive a divisor write; returns at the falling edge of the first cycle after it.
    task automatic wr(input bit hi, input logic [7:0] v);
        if (hi) begin div_hi_data = v; div_hi_we = 1'b1; end
        else    begin div_lo_data = v; div_lo_we = 1'b1; end
        @(negedge clk);
        div_hi_we = 1'b0;
        div_lo_we = 1'b0;
    endtask

    task automatic next_bit(output int gap);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!bit_tick);
    endtask

    task automatic next_sub(output int gap);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!sub_tick);
    endtask

    task automatic bit_period(input int exp, input string tag);
        int g;
        next_bit(g);
        next_bit(g);
        next_bit(g);
        check(g == exp, tag, g, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!sub_tick && !bit_tick, "R1 ticks in reset", {sub_tick, bit_tick}, 0);
        check(rx_bit == 1'b1, "R1 rx_bit reset", rx_bit, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(sub_tick == 1'b1, "R1 n=0 after reset", sub_tick, 1);
    endtask

    task automatic t_zero_div();
        int g;
        next_sub(g);
        check(g == 1, "R6 sub period n=0", g, 1);
        bit_period(64, "R6 bit period n=0 P=64");
        sel_fast = 1'b1;
        bit_period(16, "R6 bit period n=0 P=16");
        sel_fast = 1'b0;
    endtask

    task automatic t_rate();
        int g;
        int rate_x100;
        wr(1'b0, 8'd25);
        bit_period(1664, "R7 period n=25 P=64");
        next_bit(g);
        rate_x100 = (16000000 * 100) / g;
        check(rate_x100 / 100 == 9615, "R7 rate", rate_x100 / 100, 9615);
        check((rate_x100 - 960000) * 10000 / 960000 == 16, "R7 error 0.16%",
              (rate_x100 - 960000) * 10000 / 960000, 16);
    endtask

    task automatic t_modes();
        int g;
        wr(1'b1, 8'd1);
        wr(1'b0, 8'd2);
        sel_wide = 1'b0; sel_fast = 1'b0;
        bit_period(192, "R2 hi ignored narrow");
        next_sub(g); next_sub(g);
        check(g == 3, "R2 sub period narrow", g, 3);
        sel_fast = 1'b1;
        bit_period(48, "R3 narrow fast P=16");
        sel_wide = 1'b1; sel_fast = 1'b0;
        bit_period(4144, "R3 wide slow P=16");
        next_sub(g); next_sub(g);
        check(g == 259, "R2 sub period wide", g, 259);
        sel_fast = 1'b1;
        bit_period(1036, "R3 wide fast P=4");
        sel_sync = 1'b1; sel_wide = 1'b0; sel_fast = 1'b0;
        bit_period(12, "R4 sync fast=0");
        sel_fast = 1'b1;
        bit_period(12, "R4 sync fast=1");
        sel_wide = 1'b1; sel_fast = 1'b0;
        bit_period(1036, "R4 sync wide");
        sel_wide = 1'b0;
    endtask

    task automatic t_restart();
        int first;
        int g;
        wr(1'b0, 8'd25);
        repeat (37) @(negedge clk);
        wr(1'b0, 8'd5);
        check(sub_tick == 1'b1, "R5 sub tick after lo write", sub_tick, 1);
        first = -1;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (bit_tick && first < 0) first = k;
        end
        check(first == 18, "R5 first bit tick", first, 18);
        repeat (3) @(negedge clk);
        wr(1'b1, 8'd9);
        check(sub_tick == 1'b1, "R5 sub tick after hi write", sub_tick, 1);
        next_sub(g);
        check(g == 6, "R5 gap after hi write", g, 6);
    endtask

    // P=4, n=3: samples at cycles 4, 8, 12 after the write; vote visible at 13.
    task automatic t_vote(input bit a, input bit b, input bit c);
        bit exp;
        bit prev;
        bit val;
        exp = (a & b) | (a & c) | (b & c);
        sel_sync = 1'b1; sel_wide = 1'b0;
        wr(1'b0, 8'd3);
        prev = rx_bit;
        for (int k = 0; k <= 15; k++) begin
            if (k > 0) @(negedge clk);
            if (k == 12) check(bit_tick == 1'b1, "R8 bit tick at third sample", bit_tick, 1);
            if (k < 13) check(rx_bit == prev, "R8 rx_bit held", rx_bit, prev);
            if (k == 13) check(rx_bit == exp, "R8 vote", rx_bit, exp);
            if (k >= 4 && k <= 7)       val = a;
            else if (k >= 8 && k <= 11) val = b;
            else if (k == 12)           val = c;
            else                        val = ~exp;
            rx_in = val;
        end
    endtask

    // P=16, n=0: samples at cycles 7, 8, 9; vote visible at 10.
    task automatic t_vote_fast();
        bit prev;
        sel_sync = 1'b0; sel_wide = 1'b0; sel_fast = 1'b1;
        rx_in = 1'b1;
        wr(1'b0, 8'd3);
        repeat (20) @(negedge clk);
        wr(1'b0, 8'd0);
        prev = rx_bit;
        for (int k = 0; k <= 11; k++) begin
            if (k > 0) @(negedge clk);
            if (k < 10) check(rx_bit == prev, "R8 n=0 rx_bit held", rx_bit, prev);
            if (k == 10) check(rx_bit == 1'b0, "R6 R8 n=0 vote", rx_bit, 0);
            rx_in = (k == 7 || k == 9) ? 1'b0 : 1'b1;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_zero_div();
        t_rate();
        t_modes();
        t_restart();
        t_vote(1'b0, 1'b1, 1'b0);
        t_vote(1'b1, 1'b0, 1'b1);
        t_vote(1'b0, 1'b0, 1'b1);
        t_vote(1'b1, 1'b1, 1'b0);
        t_vote_fast();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule